// File: doc/BRIEF.md
# Self-Timed Serial Converter Interface Model

This block is a synthesizable device-side model of the digital serial port of a small 8-bit converter that times its own conversions. A host clocks a control byte in on the data input while the chip select is low. The first 1 bit marks the start of the byte, and the seven bits after it carry a channel select, a polarity mode, an input-type mode and a power mode. All of these are presented on output ports. The model then captures its sample input and pulls a strobe low. It runs a conversion timer counted in system clock cycles, then raises the strobe. From that point the held result can be shifted out on the data output, most significant bit first, followed by zeros.

The serial clock, chip select and data input are sampled on the system clock, so the serial clock must be several times slower than the system clock. No analog behaviour is modelled: the converted value is whatever is on the sample input when the control byte completes. The model is meant as a partner for a host controller in simulation or emulation.

Top module: `serial_adc_model`

## Requirements
- R1: While chip select is low, zero bits clocked in on rising serial clock edges before a 1 are discarded. The first 1 is the start bit, and the following seven rising edges complete the control byte.
- R2: The seven bits after the start bit map in arrival order to chan_sel[2], chan_sel[1], chan_sel[0], unipolar, single_ended, pwr_mode[1] and pwr_mode[0]. These ports hold their values until the next control byte completes.
- R3: The strobe is high after reset. It falls on the system clock edge that samples the seventh field bit. It stays low for exactly CONV_CYCLES system clock cycles and then returns high.
- R4: The result is the value on sample_in when the control byte completes. Later changes of sample_in do not alter it.
- R5: After the strobe rises, dout is 0 after the first falling serial clock edge. The second falling edge presents result bit 7, and each later falling edge presents the next lower bit down to bit 0. Every later falling edge gives 0.
- R6: While chip select is high, dout_en is 0, and the serial clock and data input have no effect.
- R7: A running conversion finishes on time whatever chip select does. The strobe is always driven and has no enable.
- R8: The result stays readable for any length of idle time after the strobe rises.
- R9: dout is 0 for as long as the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control data, sampled on rising sclk |
| sample_in | input | RES_BITS | Value to report as the conversion result |
| dout | output | 1 | Serial result data, changes on falling sclk |
| dout_en | output | 1 | High when dout should be driven (chip select low) |
| strobe | output | 1 | Low while converting, high when the result is ready |
| chan_sel | output | 3 | Captured channel select field |
| unipolar | output | 1 | Captured polarity mode bit |
| single_ended | output | 1 | Captured input-type mode bit |
| pwr_mode | output | 2 | Captured power mode field |

## Verification
The bench covers all 256 result values and all 128 field combinations. Each control byte starts after zero to two leading zeros, which catches a start detector that latches on a zero or that miscounts the field bits. The readout is checked bit by bit across sixteen falling edges. A design that gave the MSB on the first falling edge, or that left stale bits in place of the zero fill, would fail here. Some vectors change sample_in mid-conversion, which exposes a design that samples late. Others raise chip select and toggle the clock with din high during the conversion or before a byte. A design that accepted those edges or stopped its timer would fail. Further vectors idle before reading, which exposes a result register that does not hold its value.

// File: rtl/serial_adc_model.sv
module serial_adc_model #(
  parameter int CONV_CYCLES = 5000,
  parameter int RES_BITS    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                din,
  input  logic [RES_BITS-1:0] sample_in,
  output logic                dout,
  output logic                dout_en,
  output logic                strobe,
  output logic [2:0]          chan_sel,
  output logic                unipolar,
  output logic                single_ended,
  output logic [1:0]          pwr_mode
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  typedef enum logic [1:0] {IDLE, RECV, CONV, READ} state_t;
  state_t st;

  logic                sclk_q;
  logic [2:0]          nbits;
  logic [5:0]          rx;
  logic [CW-1:0]       cnt;
  logic [RES_BITS-1:0] result, sh;
  logic [1:0]          nfall;

  wire rise = sclk & ~sclk_q & ~cs_n;
  wire fall = ~sclk & sclk_q & ~cs_n;

  assign dout    = sh[RES_BITS-1];
  assign dout_en = ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= IDLE;
      sclk_q       <= 1'b0;
      nbits        <= '0;
      rx           <= '0;
      cnt          <= '0;
      result       <= '0;
      sh           <= '0;
      nfall        <= '0;
      strobe       <= 1'b1;
      chan_sel     <= '0;
      unipolar     <= 1'b0;
      single_ended <= 1'b0;
      pwr_mode     <= '0;
    end else begin
      sclk_q <= sclk;
      case (st)
        IDLE: if (rise && din) begin
          st    <= RECV;
          nbits <= '0;
        end
        RECV: if (rise) begin
          rx    <= {rx[4:0], din};
          nbits <= nbits + 3'd1;
          if (nbits == 3'd6) begin
            {chan_sel, unipolar, single_ended, pwr_mode} <= {rx, din};
            result <= sample_in;
            sh     <= '0;
            strobe <= 1'b0;
            cnt    <= CW'(CONV_CYCLES - 1);
            st     <= CONV;
          end
        end
        CONV: if (cnt == '0) begin
          strobe <= 1'b1;
          nfall  <= '0;
          st     <= READ;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: if (rise && din) begin
          st    <= RECV;
          nbits <= '0;
          sh    <= '0;
        end else if (fall) begin
          if (nfall == 2'd1) sh <= result;
          else               sh <= sh << 1;
          if (nfall != 2'd2) nfall <= nfall + 2'd1;
        end
      endcase
    end
  end
endmodule

module serial_adc_model_chk #(
  parameter int CONV_CYCLES = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic dout,
  input logic dout_en,
  input logic strobe,
  input logic [2:0] chan_sel,
  input logic [1:0] pwr_mode
);
  int unsigned lowcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      lowcnt <= 0;
    else if (strobe) lowcnt <= 0;
    else             lowcnt <= lowcnt + 1;

  a_r3_low_span: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> lowcnt == CONV_CYCLES);
  a_r1_fall_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> $past(sclk) && !$past(sclk, 2) && !$past(cs_n));
  a_r2_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && $past(!strobe)) |-> $stable(chan_sel) && $stable(pwr_mode));
  a_r9_quiet_converting: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> !dout);
  a_r6_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dout_en);
endmodule

bind serial_adc_model serial_adc_model_chk #(.CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dout(dout),
  .dout_en(dout_en), .strobe(strobe), .chan_sel(chan_sel), .pwr_mode(pwr_mode)
);

// File: tb/tb_serial_adc_model.sv
`timescale 1ns/1ps
module tb_serial_adc_model;
  localparam int CONV = 24;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [7:0] sample_in = '0;
  logic dout, dout_en, strobe, unipolar, single_ended;
  logic [2:0] chan_sel;
  logic [1:0] pwr_mode;

  int nchk = 0, nfail = 0;
  int lowrun = 0, lastlow = 0;

  always #2.5 clk = ~clk;

  serial_adc_model #(.CONV_CYCLES(CONV), .RES_BITS(8)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .sample_in(sample_in), .dout(dout), .dout_en(dout_en), .strobe(strobe),
    .chan_sel(chan_sel), .unipolar(unipolar), .single_ended(single_ended),
    .pwr_mode(pwr_mode)
  );

  always @(negedge clk)
    if (!strobe) lowrun++;
    else if (lowrun != 0) begin lastlow = lowrun; lowrun = 0; end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sclk_cycle(input logic d);
    din = d;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [6:0] pf;
    repeat (4) @(negedge clk);
    // reset state (R3, R6)
    check(strobe === 1'b1, "R3 reset strobe", strobe, 1);
    check(dout_en === 1'b0, "R6 reset dout_en", dout_en, 0);
    check({chan_sel, unipolar, single_ended, pwr_mode} === 7'd0, "R2 reset fields",
          {chan_sel, unipolar, single_ended, pwr_mode}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    pf = '0;

    for (int v = 0; v < 256; v++) begin
      logic [6:0] f;
      logic [7:0] smp;
      int wd;
      f   = 7'(v * 5 + (v >> 7));
      smp = 8'(v);
      sample_in = smp;

      if (v % 4 == 2) begin
        // R6: clocks with din high while deselected do nothing
        for (int k = 0; k < 8; k++) sclk_cycle(1'b1);
        repeat (4) @(negedge clk);
        check(strobe === 1'b1, "R6 no start while deselected", strobe, 1);
        check({chan_sel, unipolar, single_ended, pwr_mode} === pf, "R6 fields untouched",
              {chan_sel, unipolar, single_ended, pwr_mode}, pf);
        check(dout_en === 1'b0, "R6 dout_en", dout_en, 0);
      end

      cs_n = 1'b0;
      @(negedge clk);
      for (int z = 0; z < v % 3; z++) sclk_cycle(1'b0);   // R1 leading zeros
      sclk_cycle(1'b1);
      for (int b = 6; b >= 0; b--) sclk_cycle(f[b]);
      din = 1'b0;
      check(strobe === 1'b0, "R3 strobe low after byte", strobe, 0);
      check({chan_sel, unipolar, single_ended, pwr_mode} === f, "R1 R2 fields",
            {chan_sel, unipolar, single_ended, pwr_mode}, f);
      sample_in = ~smp;                                    // R4
      check(dout === 1'b0, "R9 dout quiet converting", dout, 0);

      if (v % 4 == 1) begin
        cs_n = 1'b1;                                       // R7
        for (int k = 0; k < 3; k++) sclk_cycle(1'b1);
        din = 1'b0;
        check(dout_en === 1'b0, "R6 dout_en while converting", dout_en, 0);
        check(strobe === 1'b0, "R7 strobe driven low deselected", strobe, 0);
        cs_n = 1'b0;
      end

      wd = 0;
      while (strobe !== 1'b1 && wd < 1000) begin @(negedge clk); wd++; end
      @(negedge clk);
      check(lastlow == CONV, "R3 R7 conversion length", lastlow, CONV);
      if (v % 4 == 3) repeat (50) @(negedge clk);          // R8

      for (int i = 1; i <= 16; i++) begin
        logic e;
        sclk_cycle(1'b0);
        repeat (2) @(negedge clk);
        e = (i >= 2 && i <= 9) ? smp[9 - i] : 1'b0;
        check(dout === e, "R4 R5 R8 readout bit", dout, e);
      end
      check(dout_en === 1'b1, "R6 dout_en selected", dout_en, 1);
      cs_n = 1'b1;
      pf = f;
      repeat (2) @(negedge clk);
    end
    finish_run();
  end
endmodule